// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block manages a set of dual-use pads. Each pad is read once as a configuration strap while power comes up, and afterwards drives a clock. When the supply-good indication rises, a window timer counts a fixed number of reference clock cycles. For the whole window every pad's output driver stays disabled, so an external pull resistor alone sets the pad level. On the last cycle of the window the level of every pad is captured. The drivers are then enabled, and each pad passes its own clock source.

One of the captured straps picks the rate of a companion clock output. A strap tied high gives the slower clock, with a half period of twice the base count. A strap tied low gives the faster clock, with the base half period. The companion output stays low until capture is complete. The captured straps and the done flag are cleared only when the supply-good input drops. The ordinary logic reset restarts only the companion clock divider.

Top module: `por_strap_ctrl`

## Requirements
- R1: While the window runs (supply good, capture not yet done), `pad_oe` and `pad_out` are all zero, `strap_valid` is 0 and `comp_clk` is 0.
- R2: `strap_valid` rises on exactly the `WINDOW_CYCLES`-th rising clock edge after `supply_good` goes high, and stays high until `supply_good` falls.
- R3: On that edge, bit i of `strap` takes the level of `pad_in[i]`: 1 for a pull to supply, 0 for a pull to ground. Changes on `pad_in` after capture have no effect on `strap`.
- R4: Once `strap_valid` is 1, every bit of `pad_oe` is 1 and `pad_out[i]` equals `ref_clk_in[i]`.
- R5: Asserting `rst_n` low does not change `strap` or `strap_valid`.
- R6: `comp_clk` is 0 while `strap_valid` is 0 and while `rst_n` is low.
- R7: After capture, `comp_clk` toggles with every level lasting `2*FAST_HALF` clock cycles when `strap[SEL_IDX]` is 1, and `FAST_HALF` cycles when it is 0. The first low level counts from the capture edge.
- R8: `supply_good` low clears `strap` and `strap_valid` at once. The next rise of `supply_good` starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the window and the divider |
| rst_n | input | 1 | Active-low logic reset; affects only the companion divider |
| supply_good | input | 1 | Supply above trip point; low acts as the power-cycle clear |
| pad_in | input | NUM_PADS | Level seen on each pad |
| ref_clk_in | input | NUM_PADS | Clock source driven onto each pad after capture |
| pad_out | output | NUM_PADS | Value driven onto each pad |
| pad_oe | output | NUM_PADS | Output driver enable for each pad |
| strap | output | NUM_PADS | Captured strap levels |
| strap_valid | output | 1 | Capture complete |
| comp_clk | output | 1 | Companion clock, rate picked by `strap[SEL_IDX]` |

## Verification
The assertions check on every cycle that the window counter stays in range, that the done flag never falls while supply is good, that the captured straps hold outside the capture strobe, that the divider count stays below the selected half period, and that the companion clock stays low before capture. Several behaviours can only be shown by the bench scenarios. These are the exact edge on which capture happens, that the pad level on that edge is what gets stored, the half-period length for each strap setting, and that a logic reset leaves the straps alone while a supply drop clears them. The bench runs all strap patterns through a full power-up each, and measures the companion clock run lengths against the expected half period.

// File: rtl/por_strap_pkg.sv
package por_strap_pkg;
   typedef enum logic {
      PH_WINDOW = 1'b0,
      PH_RUN    = 1'b1
   } phase_e;
endpackage

// File: rtl/por_window_timer.sv
module por_window_timer
   import por_strap_pkg::*;
#(
   parameter int WINDOW_CYCLES = 100000
) (
   input  logic clk,
   input  logic supply_good,
   output logic capture_stb,
   output logic window_done
);
   localparam int CW = $clog2(WINDOW_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

   phase_e          phase;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge supply_good) begin
      if (!supply_good) begin
         phase <= PH_WINDOW;
         cnt   <= '0;
      end else if (phase == PH_WINDOW) begin
         if (cnt == LAST) phase <= PH_RUN;
         else             cnt   <= cnt + 1'b1;
      end
   end

   assign capture_stb = (phase == PH_WINDOW) && (cnt == LAST);
   assign window_done = (phase == PH_RUN);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!supply_good)
      cnt <= LAST); // R2
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!supply_good)
      window_done |=> window_done); // R2
endmodule

// File: rtl/por_strap_capture.sv
module por_strap_capture #(
   parameter int NUM_PADS = 2
) (
   input  logic                clk,
   input  logic                supply_good,
   input  logic                capture_stb,
   input  logic [NUM_PADS-1:0] pad_in,
   output logic [NUM_PADS-1:0] strap
);
   for (genvar i = 0; i < NUM_PADS; i++) begin : g_bit
      always_ff @(posedge clk or negedge supply_good) begin
         if (!supply_good)     strap[i] <= 1'b0;
         else if (capture_stb) strap[i] <= pad_in[i];
      end
   end

   AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!supply_good)
      !capture_stb |=> $stable(strap)); // R3
endmodule

// File: rtl/por_comp_clk_gen.sv
module por_comp_clk_gen #(
   parameter int FAST_HALF = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic slow_sel,
   output logic comp_clk
);
   localparam int SLOW_HALF = 2 * FAST_HALF;
   localparam int DW        = $clog2(SLOW_HALF + 1);

   logic [DW-1:0] dcnt;
   logic [DW-1:0] half;

   assign half = slow_sel ? DW'(SLOW_HALF) : DW'(FAST_HALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt     <= '0;
         comp_clk <= 1'b0;
      end else if (!enable) begin
         dcnt     <= '0;
         comp_clk <= 1'b0;
      end else if (dcnt == half - 1'b1) begin
         dcnt     <= '0;
         comp_clk <= ~comp_clk;
      end else begin
         dcnt     <= dcnt + 1'b1;
      end
   end

   AST_DCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt < half); // R7
endmodule

// File: rtl/por_strap_ctrl.sv
module por_strap_ctrl #(
   parameter int WINDOW_CYCLES = 100000,
   parameter int NUM_PADS      = 2,
   parameter int SEL_IDX       = 1,
   parameter int FAST_HALF     = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                supply_good,
   input  logic [NUM_PADS-1:0] pad_in,
   input  logic [NUM_PADS-1:0] ref_clk_in,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe,
   output logic [NUM_PADS-1:0] strap,
   output logic                strap_valid,
   output logic                comp_clk
);
   if (WINDOW_CYCLES < 2) begin : g_bad_window
      $error("WINDOW_CYCLES must be at least 2");
   end
   if (NUM_PADS < 1) begin : g_bad_pads
      $error("NUM_PADS must be at least 1");
   end
   if (SEL_IDX < 0 || SEL_IDX >= NUM_PADS) begin : g_bad_sel
      $error("SEL_IDX must index a pad");
   end
   if (FAST_HALF < 1) begin : g_bad_half
      $error("FAST_HALF must be at least 1");
   end

   logic capture_stb;
   logic done;
   logic div_rst_n;

   por_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
      .clk         (clk),
      .supply_good (supply_good),
      .capture_stb (capture_stb),
      .window_done (done)
   );

   por_strap_capture #(.NUM_PADS(NUM_PADS)) u_capture (
      .clk         (clk),
      .supply_good (supply_good),
      .capture_stb (capture_stb),
      .pad_in      (pad_in),
      .strap       (strap)
   );

   assign div_rst_n = rst_n & supply_good;

   por_comp_clk_gen #(.FAST_HALF(FAST_HALF)) u_comp (
      .clk      (clk),
      .rst_n    (div_rst_n),
      .enable   (done),
      .slow_sel (strap[SEL_IDX]),
      .comp_clk (comp_clk)
   );

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      assign pad_oe[i]  = done;
      assign pad_out[i] = done & ref_clk_in[i];
   end

   assign strap_valid = done;

   AST_COMP_QUIET: assert property (@(posedge clk) disable iff (!supply_good || !rst_n)
      !strap_valid |-> !comp_clk); // R6
endmodule

// File: tb/por_strap_ctrl_tb.sv
module por_strap_ctrl_tb;
   localparam int W  = 20;
   localparam int NP = 2;
   localparam int SI = 1;
   localparam int FH = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_good = 1'b0;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] ref_clk_in = '0;
   logic [NP-1:0] pad_out, pad_oe, strap;
   logic          strap_valid, comp_clk;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   por_strap_ctrl #(.WINDOW_CYCLES(W), .NUM_PADS(NP), .SEL_IDX(SI), .FAST_HALF(FH)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .pad_in(pad_in),
      .ref_clk_in(ref_clk_in), .pad_out(pad_out), .pad_oe(pad_oe), .strap(strap),
      .strap_valid(strap_valid), .comp_clk(comp_clk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // reset state with supply low
      chk(strap_valid == 1'b0, "R8", strap_valid, 0);
      chk(comp_clk == 1'b0, "R6", comp_clk, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int p = 0; p < (1 << NP); p++) begin
         int half_exp;
         int run;
         int changes;
         logic prev;
         // power cycle clears everything
         supply_good = 1'b0;
         pad_in = NP'(p);
         ref_clk_in = '1;
         #1;
         chk(strap_valid == 1'b0 && strap == '0, "R8", {strap_valid, strap}, 0);
         @(negedge clk);
         supply_good = 1'b1;
         for (int k = 1; k < W; k++) begin
            @(negedge clk);
            chk(strap_valid == 1'b0, "R2", strap_valid, 0);
            chk(pad_oe == '0 && pad_out == '0 && comp_clk == 1'b0, "R1",
                {pad_oe, pad_out, comp_clk}, 0);
         end
         @(negedge clk);
         chk(strap_valid == 1'b1, "R2", strap_valid, 1);
         chk(strap == NP'(p), "R3", strap, p);
         chk(pad_oe == '1, "R4", pad_oe, (1 << NP) - 1);
         // pad level changes after capture must be ignored
         pad_in = ~NP'(p);
         ref_clk_in = NP'(1);
         #1;
         chk(pad_out == NP'(1), "R4", pad_out, 1);
         ref_clk_in = NP'(2);
         #1;
         chk(pad_out == NP'(2), "R4", pad_out, 2);
         half_exp = p[SI] ? 2 * FH : FH;
         prev = comp_clk;
         run = 1;
         changes = 0;
         while (changes < 4) begin
            @(negedge clk);
            if (comp_clk == prev) run++;
            else begin
               chk(run == half_exp, "R7", run, half_exp);
               run = 1;
               prev = comp_clk;
               changes++;
            end
         end
         chk(strap == NP'(p), "R3", strap, p);
         // logic reset leaves the straps in place
         rst_n = 1'b0;
         @(negedge clk);
         chk(comp_clk == 1'b0, "R6", comp_clk, 0);
         chk(strap_valid == 1'b1 && strap == NP'(p), "R5", {strap_valid, strap}, (1 << NP) | p);
         @(negedge clk);
         rst_n = 1'b1;
         @(negedge clk);
         chk(strap_valid == 1'b1 && strap == NP'(p), "R5", {strap_valid, strap}, (1 << NP) | p);
      end
      supply_good = 1'b0;
      #1;
      chk(strap_valid == 1'b0 && strap == '0, "R8", {strap_valid, strap}, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule